// File: doc/BRIEF.md
# Character I/O Register Port

This peripheral puts one character source (such as a keyboard) and one character sink (such as a display) on a processor's load/store bus. Software finds four byte-wide registers inside a small reserved address window. No memory lives there. A status register holds one ready flag per side, plus a sticky overrun bit. The receive data register takes each character the source delivers. Writing the transmit data register hands a character to the sink.

The ready flags are set from the device side. Processor accesses clear them as a side effect:

- A read of the receive register clears the receive flag.
- A write of the transmit register clears the transmit flag.
- The transmit flag comes back once the sink pulses its done input.

A level interrupt request is raised while a ready flag is set and the control register enables that side.

Register offsets in the window are: 0 receive data, 1 transmit data, 2 status, 3 control. Reads are combinational. Every state change happens on the rising clock edge of the cycle in which the strobe is high.

Top module: `char_io_port`

## Requirements
- R1: After reset, both data registers read 0, the receive flag is 0, the transmit flag is 1, the overrun bit is 0, both interrupt enables are 0, tx_valid_o is 0 and irq_o is 0.
- R2: Only offsets 0 to 3 of the window are mapped. A read of any other offset returns 0, and a write to one changes nothing. rdata_o is 0 whenever rd_i is low.
- R3: A cycle with rx_valid_i high loads rx_data_i into the receive register, which reads back at offset 0, and sets status bit 0 from the next cycle on.
- R4: A read at offset 0 clears status bit 0 after that edge. If rx_valid_i is high in the same cycle, the new character is kept and bit 0 stays 1.
- R5: A write at offset 1 drives wdata_i onto tx_data_o, which also reads back at offset 1, and clears status bit 1. tx_valid_o is high exactly while status bit 1 is 0.
- R6: tx_done_i while status bit 1 is 0 sets it again. tx_done_i while bit 1 is already 1 has no effect. A write at offset 1 in the same cycle as tx_done_i wins, so bit 1 ends at 0.
- R7: A character that arrives while status bit 0 is 1, and is not met by a same-cycle read at offset 0, overwrites the receive register and sets status bit 4. A read at offset 2 clears bit 4, unless a new overrun occurs in that same cycle.
- R8: Writes at offset 2 are ignored. At offset 3, bit 2 is the receive interrupt enable and bit 3 the transmit interrupt enable; both are writable and read back. All other control and status bits read 0.
- R9: irq_o is high exactly while (status bit 0 and control bit 2) or (status bit 1 and control bit 3). It therefore falls in the cycle after the read that empties the receive side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register offset inside the window |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| rx_valid_i | input | 1 | Source delivers a character this cycle |
| rx_data_i | input | DATA_W | Character from source |
| tx_data_o | output | DATA_W | Character for sink |
| tx_valid_o | output | 1 | A character awaits the sink |
| tx_done_i | input | 1 | Sink has taken the character |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the collisions between the device side and the processor side.

- **Character arriving in the cycle it is read.** A design that lets the read win would lose the fresh character's ready flag.
- **Second character arriving before the first is read.** A design that checks the flag after updating it would never flag overrun, or would flag it on every arrival.
- **Status read coinciding with a new overrun.** A design that lets the read win would drop the new overrun.
- **Transmit write landing on the same edge as done.** A design that lets done win would leave the flag set while a character is still pending.

Writes to status and to unmapped offsets, and done pulses while idle, are also driven. A design that decodes loosely would show changed read-back values or a stray interrupt.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
  typedef enum logic [1:0] {
    OFS_RXD  = 2'd0,
    OFS_TXD  = 2'd1,
    OFS_STAT = 2'd2,
    OFS_CTRL = 2'd3
  } reg_ofs_e;

  localparam int ST_RX_RDY = 0;
  localparam int ST_TX_RDY = 1;
  localparam int ST_OVR    = 4;
  localparam int CT_RX_IE  = 2;
  localparam int CT_TX_IE  = 3;
endpackage

// File: rtl/char_io_rx.sv
module char_io_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_valid_i,
  input  logic [DATA_W-1:0] dev_data_i,
  input  logic              take_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              ovr_o
);
  logic lost;

  // Overrun only when the old character is still unread after this edge.
  assign lost = dev_valid_i & rdy_o & ~take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      rdy_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (dev_valid_i) data_o <= dev_data_i;

      if (dev_valid_i)  rdy_o <= 1'b1;
      else if (take_i)  rdy_o <= 1'b0;

      if (lost)           ovr_o <= 1'b1;
      else if (stat_rd_i) ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/char_io_tx.sv
module char_io_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      rdy_o  <= 1'b1;
    end else if (load_i) begin
      data_o <= load_data_i;
      rdy_o  <= 1'b0;
    end else if (done_i) begin
      rdy_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/char_io_port.sv
module char_io_port
  import char_io_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_done_i,
  output logic              irq_o
);
  logic              hit;
  reg_ofs_e          ofs;
  logic [DATA_W-1:0] rx_dat;
  logic              rx_rdy, tx_rdy, rx_ovr;
  logic              rx_ie, tx_ie;
  logic [DATA_W-1:0] stat_v, ctrl_v, rd_mux;
  logic              take_rx, load_tx, rd_stat, wr_ctrl;

  generate
    if (ADDR_W > 2) begin : g_wide
      assign hit = ~|addr_i[ADDR_W-1:2];
    end else begin : g_narrow
      assign hit = 1'b1;
    end
  endgenerate

  assign ofs     = reg_ofs_e'(addr_i[1:0]);
  assign take_rx = rd_i & hit & (ofs == OFS_RXD);
  assign rd_stat = rd_i & hit & (ofs == OFS_STAT);
  assign load_tx = wr_i & hit & (ofs == OFS_TXD);
  assign wr_ctrl = wr_i & hit & (ofs == OFS_CTRL);

  char_io_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_valid_i(rx_valid_i),
    .dev_data_i (rx_data_i),
    .take_i     (take_rx),
    .stat_rd_i  (rd_stat),
    .data_o     (rx_dat),
    .rdy_o      (rx_rdy),
    .ovr_o      (rx_ovr)
  );

  char_io_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_tx),
    .load_data_i(wdata_i),
    .done_i     (tx_done_i),
    .data_o     (tx_data_o),
    .rdy_o      (tx_rdy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
    end else if (wr_ctrl) begin
      rx_ie <= wdata_i[CT_RX_IE];
      tx_ie <= wdata_i[CT_TX_IE];
    end
  end

  always_comb begin
    stat_v            = '0;
    stat_v[ST_RX_RDY] = rx_rdy;
    stat_v[ST_TX_RDY] = tx_rdy;
    stat_v[ST_OVR]    = rx_ovr;
    ctrl_v            = '0;
    ctrl_v[CT_RX_IE]  = rx_ie;
    ctrl_v[CT_TX_IE]  = tx_ie;
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (ofs)
        OFS_RXD:  rd_mux = rx_dat;
        OFS_TXD:  rd_mux = tx_data_o;
        OFS_STAT: rd_mux = stat_v;
        OFS_CTRL: rd_mux = ctrl_v;
        default:  rd_mux = '0;
      endcase
    end
  end

  assign rdata_o    = rd_i ? rd_mux : '0;
  assign tx_valid_o = ~tx_rdy;
  assign irq_o      = (rx_rdy & rx_ie) | (tx_rdy & tx_ie);
endmodule

// File: rtl/char_io_port_chk.sv
module char_io_port_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_done_i,
  input logic              irq_o,
  input logic              rx_rdy,
  input logic              tx_rdy,
  input logic              rx_ovr,
  input logic              tx_ie
);
  logic rd_rx, wr_tx, rd_st, wr_ct, unmapped;

  assign unmapped = (ADDR_W > 2) ? (addr_i >= ADDR_W'(4)) : 1'b0;
  assign rd_rx = rd_i && addr_i == ADDR_W'(0);
  assign wr_tx = wr_i && addr_i == ADDR_W'(1);
  assign rd_st = rd_i && addr_i == ADDR_W'(2);
  assign wr_ct = wr_i && addr_i == ADDR_W'(3);

  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && unmapped) |-> rdata_o == '0);

  assert_rx_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_rdy && (rd_rx ? rdata_o == $past(rx_data_i) : 1'b1));

  assert_rx_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && !rx_valid_i) |=> !rx_rdy);

  assert_tx_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> !tx_rdy && tx_data_o == $past(wdata_i));

  assert_tx_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_rdy && tx_done_i && !wr_tx) |=> tx_rdy);

  assert_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_rdy && !rd_rx) |=> rx_ovr);

  assert_overrun_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st && !rx_valid_i) |=> !rx_ovr);

  assert_irq_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && !rx_valid_i && !tx_ie && !wr_ct) |=> !irq_o);
endmodule

bind char_io_port char_io_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rx_valid_i(rx_valid_i),
  .rx_data_i (rx_data_i),
  .tx_data_o (tx_data_o),
  .tx_done_i (tx_done_i),
  .irq_o     (irq_o),
  .rx_rdy    (rx_rdy),
  .tx_rdy    (tx_rdy),
  .rx_ovr    (rx_ovr),
  .tx_ie     (tx_ie)
);

// File: tb/test_char_io_port.sv
module test_char_io_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic [7:0] tx_data_o;
  logic       tx_valid_o;
  logic       tx_done_i = 1'b0;
  logic       irq_o;

  int n_run = 0, n_fail = 0;

  // reference state
  int m_rxd = 0, m_txd = 0, m_rxr = 0, m_txr = 1, m_ovr = 0, m_rie = 0, m_tie = 0;

  always #4 clk_i = ~clk_i;

  char_io_port i_char_io_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .tx_done_i(tx_done_i), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int st = m_rxr | (m_txr << 1) | (m_ovr << 4);
    chk("R5 tx_data_o", 32'(tx_data_o), 32'(m_txd));
    chk("R5 tx_valid_o", 32'(tx_valid_o), 32'(m_txr == 0));
    chk("R9 irq_o", 32'(irq_o), 32'((m_rxr & m_rie) | (m_txr & m_tie)));
    if (!rd_i) chk("R2 idle rdata", 32'(rdata_o), 0);
    else case (addr_i)
      3'd0: chk("R3 rx data", 32'(rdata_o), 32'(m_rxd));
      3'd1: chk("R5 tx readback", 32'(rdata_o), 32'(m_txd));
      3'd2: begin
        chk("R4 status bit0", 32'(rdata_o[0]), 32'(st & 1));
        chk("R6 status bit1", 32'(rdata_o[1]), 32'((st >> 1) & 1));
        chk("R7 status bit4", 32'(rdata_o[4]), 32'((st >> 4) & 1));
        chk("R8 status spare", 32'({rdata_o[7:5], rdata_o[3:2]}), 0);
      end
      3'd3: chk("R8 control", 32'(rdata_o), 32'((m_rie << 2) | (m_tie << 3)));
      default: chk("R2 unmapped", 32'(rdata_o), 0);
    endcase
  endtask

  task automatic step(bit rd, bit wr, logic [2:0] a, logic [7:0] wd,
                      bit rv, logic [7:0] rdat, bit td);
    bit rd0, rd2, wr1, wr3;
    int lost;
    @(negedge clk_i);
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd;
    rx_valid_i = rv; rx_data_i = rdat; tx_done_i = td;
    #1;
    compare();
    @(posedge clk_i);
    rd0 = rd && a == 0; rd2 = rd && a == 2; wr1 = wr && a == 1; wr3 = wr && a == 3;
    lost = rv && m_rxr && !rd0;
    m_ovr = lost ? 1 : (rd2 ? 0 : m_ovr);
    if (rv) begin m_rxd = int'(rdat); m_rxr = 1; end
    else if (rd0) m_rxr = 0;
    if (wr1) begin m_txd = int'(wd); m_txr = 0; end
    else if (td) m_txr = 1;
    if (wr3) begin m_rie = int'(wd[2]); m_tie = int'(wd[3]); end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    rd_i = 1'b1; addr_i = 3'd2; #1;
    chk("R1 status", 32'(rdata_o), 32'h02);
    addr_i = 3'd0; #1;
    chk("R1 rx data", 32'(rdata_o), 0);
    chk("R1 tx_data_o", 32'(tx_data_o), 0);
    chk("R1 tx_valid_o", 32'(tx_valid_o), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    rd_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    step(1, 0, 3, 0, 0, 0, 0);                  // R1 enables zero
    // R3/R9: character with interrupts off, then enabled
    step(0, 0, 0, 0, 1, 8'h41, 0);
    step(1, 0, 2, 0, 0, 0, 0);
    step(0, 1, 3, 8'hFF, 0, 0, 0);              // R8 only bits 2,3 stick
    step(1, 0, 3, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);                  // R4 read clears
    step(0, 0, 0, 0, 0, 0, 0);                  // R9 irq back on tx side
    step(0, 1, 3, 8'h04, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);                  // R9 irq low
    // R7: overrun, then status read clears
    step(0, 0, 0, 0, 1, 8'h10, 0);
    step(0, 0, 0, 0, 1, 8'h11, 0);
    step(1, 0, 2, 0, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0);
    // R7: status read with new overrun in same cycle keeps bit 4
    step(1, 0, 2, 0, 1, 8'h12, 0);
    step(1, 0, 2, 0, 0, 0, 0);
    // R4: read and new character in same cycle
    step(1, 0, 0, 0, 1, 8'h20, 0);
    step(1, 0, 2, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    // R5/R6: transmit path
    step(0, 1, 1, 8'h55, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);                  // R6 done while idle ignored
    step(0, 1, 1, 8'h66, 0, 0, 0);
    step(0, 1, 1, 8'h77, 0, 0, 1);              // R6 write beats done
    step(1, 0, 2, 0, 0, 0, 0);
    // R8/R2: status write and unmapped writes ignored
    step(0, 1, 2, 8'hFF, 0, 0, 0);
    step(0, 1, 5, 8'hFF, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0);
    step(1, 0, 3, 0, 0, 0, 0);
    step(1, 0, 6, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      bit acc = ($urandom % 3) != 0;
      bit rw  = $urandom % 2;
      step(acc & rw, acc & ~rw, 3'($urandom), 8'($urandom),
           ($urandom % 4) == 0, 8'($urandom), ($urandom % 4) == 0);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule